// File: doc/BRIEF.md
# Buck Converter Soft-Start and Fault Sequencer

This block is the supervisory controller of a synchronous step-down regulator. It takes digitized comparator results (supply ready, shutdown request, over-current, under-voltage and over-voltage) and decides when the converter may switch. It produces a reference code for the error amplifier that ramps from zero to full scale during start-up. It also produces a PWM enable, a force-both-gates-off override and a force-low-side-on override.

Time is counted in ticks of a clock-enable input that stands in for the switching clock. Over-current restarts the ramp and latches the converter off once the configured number of events has been counted. Under-voltage causes a timed hiccup and a retry, with no limit on retries. Over-voltage keeps the converter in its current state but forces the low-side switch on while the condition lasts. A shutdown request overrides every fault, and loss of supply returns the block to its reset state.

Top module: `buck_supervisor`

## Requirements
- R1: While rst_n is low, and in the cycle after any clock edge that saw supply_ok low, the block reports state code 0 (reset), pwm_en 0, gates_off 1, low_on 0 and ramp_code 0.
- R2: From reset, with supply_ok high and shdn_req low, the block enters soft-start (state code 1) on the next clock edge. Loss of supply_ok returns it to reset (state 0) on the next edge from any state.
- R3: In soft-start, ramp_code equals floor(k*(2^CODE_W-1)/SS_TICKS), where k is the number of cycles with tick high counted since the ramp began. Cycles with tick low leave the code unchanged. One edge after k reaches SS_TICKS the block enters run (state code 2), where ramp_code holds full scale.
- R4: An over-current flag seen in soft-start or run, other than the final counted event, returns the block to soft-start on the next edge with the ramp restarted from k=0.
- R5: The OC_LIMIT-th over-current event since the last clear moves the block to latched-off (state code 4) on the next edge. It stays there whatever the fault flags and tick do, until a shutdown request or a loss of supply.
- R6: shdn_req high with supply_ok high moves the block to shutdown (state code 5) on the next edge. This takes priority over every fault and clears the over-current event count. Releasing shdn_req returns the block to soft-start one edge later.
- R7: An under-voltage flag seen in run moves the block to hiccup wait (state code 3). The block returns to soft-start one edge after UV_WAIT_TICKS tick cycles have been counted there. Under-voltage events never count toward the latch.
- R8: The under-voltage flag has no effect while the block is in soft-start.
- R9: In soft-start or run, low_on follows ov_flag in the same cycle and the state is not changed by it. In every other state, low_on stays 0.
- R10: When over-current and under-voltage are flagged in the same run cycle, the over-current path wins and the next state is soft-start, not hiccup wait.
- R11: pwm_en is 1 exactly in soft-start and run, and gates_off is its complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base clock enable (one per switching period) |
| supply_ok | input | 1 | Supply power-on-reset comparator: supply ready |
| shdn_req | input | 1 | Shutdown request |
| oc_flag | input | 1 | Over-current comparator result |
| uv_flag | input | 1 | Feedback under-voltage comparator result |
| ov_flag | input | 1 | Feedback over-voltage comparator result |
| ramp_code | output | CODE_W | Soft-start reference code for the amplifier |
| pwm_en | output | 1 | Modulator may switch |
| gates_off | output | 1 | Force both gates off |
| low_on | output | 1 | Force low-side gate on (over-voltage clamp) |
| state_o | output | 3 | Sequencer state code |

## Verification
Over-current and under-voltage can both be flagged in the same run cycle. Shutdown can also coincide with an over-current event. The bench raises each pair together for one cycle and reads the state code one edge later: soft-start is expected for the first pair and shutdown for the second. After a shutdown that coincided with an over-current event, the bench checks that the event count was cleared. It does this by counting further events and confirming that the latch needs the full limit again.

// File: rtl/buck_sup_pkg.sv
package buck_sup_pkg;

  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_SOFT    = 3'd1,
    ST_RUN     = 3'd2,
    ST_HICCUP  = 3'd3,
    ST_LATCHED = 3'd4,
    ST_SHDN    = 3'd5
  } sup_state_t;

  // Ramp code after 'step' ticks of a 'steps'-tick ramp to 'full'.
  function automatic int unsigned ramp_value(int unsigned step,
                                             int unsigned steps,
                                             int unsigned full);
    return (step * full) / steps;
  endfunction

  function automatic logic is_switching(sup_state_t s);
    return (s == ST_SOFT) || (s == ST_RUN);
  endfunction

endpackage

// File: rtl/sup_interval_timer.sv
module sup_interval_timer #(
  parameter int unsigned LIMIT = 960,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic          tick,
  output logic [CW-1:0] cnt,
  output logic          done
);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (clr)                        cnt <= '0;
    else if (run && tick && cnt != LIM)  cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM);
endmodule

// File: rtl/sup_oc_counter.sv
module sup_oc_counter #(
  parameter int unsigned OC_LIMIT = 4,
  localparam int unsigned CW = $clog2(OC_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last_one
);
  localparam logic [CW-1:0] LAST = CW'(OC_LIMIT - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (inc && cnt != LAST + 1'b1) cnt <= cnt + 1'b1;
  end

  assign last_one = (cnt == LAST);
endmodule

// File: rtl/sup_ctrl_fsm.sv
module sup_ctrl_fsm
  import buck_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       shdn_req,
  input  logic       oc_flag,
  input  logic       uv_flag,
  input  logic       ramp_done,
  input  logic       wait_done,
  input  logic       oc_last,
  output sup_state_t state,
  output logic       oc_event,
  output logic       uv_event
);
  sup_state_t nxt;
  logic       live;

  assign live     = supply_ok && !shdn_req;
  assign oc_event = live && oc_flag && is_switching(state);
  assign uv_event = live && uv_flag && (state == ST_RUN);

  always_comb begin
    nxt = state;
    if (!supply_ok)     nxt = ST_RESET;
    else if (shdn_req)  nxt = ST_SHDN;
    else begin
      unique case (state)
        ST_RESET, ST_SHDN: nxt = ST_SOFT;
        ST_SOFT: begin
          if (oc_event)       nxt = oc_last ? ST_LATCHED : ST_SOFT;
          else if (ramp_done) nxt = ST_RUN;
        end
        ST_RUN: begin
          if (oc_event)       nxt = oc_last ? ST_LATCHED : ST_SOFT;
          else if (uv_event)  nxt = ST_HICCUP;
        end
        ST_HICCUP:  if (wait_done) nxt = ST_SOFT;
        ST_LATCHED: nxt = ST_LATCHED;
        default:    nxt = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= nxt;
  end
endmodule

// File: rtl/buck_supervisor.sv
module buck_supervisor
  import buck_sup_pkg::*;
#(
  parameter int unsigned CODE_W        = 10,
  parameter int unsigned SS_TICKS      = 960,
  parameter int unsigned UV_WAIT_TICKS = 960,
  parameter int unsigned OC_LIMIT      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              supply_ok,
  input  logic              shdn_req,
  input  logic              oc_flag,
  input  logic              uv_flag,
  input  logic              ov_flag,
  output logic [CODE_W-1:0] ramp_code,
  output logic              pwm_en,
  output logic              gates_off,
  output logic              low_on,
  output logic [2:0]        state_o
);
  localparam int unsigned FULL = (1 << CODE_W) - 1;
  localparam int unsigned SCW  = $clog2(SS_TICKS + 1);
  localparam int unsigned HCW  = $clog2(UV_WAIT_TICKS + 1);

  sup_state_t     state;
  logic           oc_event, uv_event, oc_last;
  logic           ramp_done, wait_done;
  logic [SCW-1:0] ramp_cnt;
  logic [HCW-1:0] wait_cnt;
  logic           in_soft, in_hic;

  assign in_soft = (state == ST_SOFT);
  assign in_hic  = (state == ST_HICCUP);

  sup_ctrl_fsm u_fsm (
    .clk, .rst_n, .supply_ok, .shdn_req, .oc_flag, .uv_flag,
    .ramp_done, .wait_done, .oc_last,
    .state, .oc_event, .uv_event
  );

  sup_interval_timer #(.LIMIT(SS_TICKS)) u_ramp_tmr (
    .clk, .rst_n,
    .clr (!in_soft || oc_event),
    .run (in_soft),
    .tick,
    .cnt (ramp_cnt),
    .done(ramp_done)
  );

  sup_interval_timer #(.LIMIT(UV_WAIT_TICKS)) u_wait_tmr (
    .clk, .rst_n,
    .clr (!in_hic),
    .run (in_hic),
    .tick,
    .cnt (wait_cnt),
    .done(wait_done)
  );

  sup_oc_counter #(.OC_LIMIT(OC_LIMIT)) u_oc_cnt (
    .clk, .rst_n,
    .clr     ((state == ST_RESET) || (state == ST_SHDN)),
    .inc     (oc_event),
    .last_one(oc_last)
  );

  always_comb begin
    unique case (state)
      ST_SOFT: ramp_code = CODE_W'(ramp_value(int'(ramp_cnt), SS_TICKS, FULL));
      ST_RUN:  ramp_code = CODE_W'(FULL);
      default: ramp_code = '0;
    endcase
  end

  assign pwm_en    = is_switching(state);
  assign gates_off = !pwm_en;
  assign low_on    = pwm_en && ov_flag;
  assign state_o   = state;
endmodule

// File: rtl/buck_supervisor_chk.sv
module buck_supervisor_chk #(
  parameter int unsigned CODE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              supply_ok,
  input logic              shdn_req,
  input logic              oc_flag,
  input logic              uv_flag,
  input logic              ov_flag,
  input logic              oc_event,
  input logic [CODE_W-1:0] ramp_code,
  input logic              pwm_en,
  input logic              gates_off,
  input logic [2:0]        state_o
);
  // R2
  supply_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> state_o == 3'd0);

  // R6
  shdn_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && shdn_req) |=> state_o == 3'd5);

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4 && supply_ok && !shdn_req) |=> state_o == 3'd4);

  // R8
  uv_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1 && uv_flag && !oc_flag && supply_ok && !shdn_req)
      |=> state_o != 3'd3);

  // R3
  ramp_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1 && !oc_event && supply_ok && !shdn_req)
      |=> ramp_code >= $past(ramp_code));

  // R9
  ov_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2 && ov_flag && !oc_flag && !uv_flag && supply_ok && !shdn_req)
      |=> state_o == 3'd2);

  // R10
  oc_over_uv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2 && oc_event && uv_flag) |=> state_o != 3'd3);

  // R11
  gate_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_en != gates_off);
endmodule

bind buck_supervisor buck_supervisor_chk #(.CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .shdn_req(shdn_req),
  .oc_flag(oc_flag), .uv_flag(uv_flag), .ov_flag(ov_flag),
  .oc_event(oc_event), .ramp_code(ramp_code), .pwm_en(pwm_en),
  .gates_off(gates_off), .state_o(state_o)
);

// File: tb/buck_supervisor_tb_top.sv
module buck_supervisor_tb_top;
  localparam int W = 10, SS = 10, UVW = 6, OCL = 4;
  localparam int FS = 1023;

  logic clk = 0, rst_n = 0, tick = 0;
  logic supply_ok = 0, shdn_req = 0, oc_flag = 0, uv_flag = 0, ov_flag = 0;
  logic [W-1:0] ramp_code;
  logic pwm_en, gates_off, low_on;
  logic [2:0] state_o;
  int checks = 0, bad = 0;

  always #10 clk = ~clk;

  buck_supervisor #(.CODE_W(W), .SS_TICKS(SS), .UV_WAIT_TICKS(UVW), .OC_LIMIT(OCL)) dut_i (
    .clk, .rst_n, .tick, .supply_ok, .shdn_req, .oc_flag, .uv_flag, .ov_flag,
    .ramp_code, .pwm_en, .gates_off, .low_on, .state_o);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  function automatic int exp_code(int k);
    int q;
    q = 0;
    for (int i = 0; i < FS; i++) q += k;  // k*FS by repeated addition
    return q / SS;
  endfunction

  task automatic to_run();
    supply_ok = 1; shdn_req = 0; tick = 1;
    oc_flag = 0; uv_flag = 0; ov_flag = 0;
    while (state_o != 3'd2) cyc();
    tick = 0;
  endtask

  task automatic t_reset();
    #5;
    chk("R1 state", state_o, 0);
    chk("R1 pwm_en", pwm_en, 0);
    chk("R1 gates_off", gates_off, 1);
    chk("R1 ramp", ramp_code, 0);
    chk("R1 low_on", low_on, 0);
    rst_n = 1; cyc(2);
    chk("R1 held without supply", state_o, 0);
    supply_ok = 1; cyc();
    chk("R2 enter soft-start", state_o, 1);
  endtask

  task automatic t_ramp();
    chk("R3 code at k=0", ramp_code, 0);
    chk("R11 pwm_en in soft", pwm_en, 1);
    cyc(3);
    chk("R3 tick low holds", ramp_code, 0);
    tick = 1;
    for (int k = 1; k <= SS; k++) begin
      cyc();
      chk("R3 ramp step", ramp_code, exp_code(k));
      chk("R3 still soft", state_o, 1);
    end
    cyc();
    chk("R3 run reached", state_o, 2);
    chk("R3 full scale", ramp_code, FS);
    tick = 0;
  endtask

  task automatic t_uv_mask();
    supply_ok = 0; cyc();
    chk("R2 supply loss", state_o, 0);
    supply_ok = 1; cyc();
    uv_flag = 1; tick = 1; cyc(4);
    chk("R8 uv ignored in soft", state_o, 1);
    chk("R8 ramp continues", ramp_code, exp_code(4));
    uv_flag = 0;
    to_run();
  endtask

  task automatic t_hiccup();
    uv_flag = 1; cyc(); uv_flag = 0;
    chk("R7 hiccup entered", state_o, 3);
    chk("R11 gates_off in hiccup", gates_off, 1);
    ov_flag = 1; #1;
    chk("R9 low_on off in hiccup", low_on, 0);
    ov_flag = 0;
    tick = 1; cyc(UVW);
    chk("R7 still waiting", state_o, 3);
    cyc();
    chk("R7 retry soft-start", state_o, 1);
    chk("R7 ramp restarts", ramp_code, 0);
    // repeated UV never latches
    for (int r = 0; r < OCL + 1; r++) begin
      to_run(); uv_flag = 1; cyc(); uv_flag = 0; tick = 1; cyc(UVW + 1);
    end
    chk("R7 no latch after many uv", state_o, 1);
    to_run();
  endtask

  task automatic t_ov();
    ov_flag = 1; #1;
    chk("R9 low_on follows ov", low_on, 1);
    cyc();
    chk("R9 state kept", state_o, 2);
    ov_flag = 0; #1;
    chk("R9 low_on drops", low_on, 0);
  endtask

  task automatic t_oc_latch();
    for (int e = 1; e < OCL; e++) begin
      oc_flag = 1; cyc(); oc_flag = 0;
      chk("R4 restart soft", state_o, 1);
      chk("R4 ramp zero", ramp_code, 0);
      to_run();
    end
    oc_flag = 1; cyc(); oc_flag = 0;
    chk("R5 latched", state_o, 4);
    chk("R5 gates off", gates_off, 1);
    oc_flag = 1; uv_flag = 1; ov_flag = 1; tick = 1; cyc(5);
    chk("R5 latch holds", state_o, 4);
    chk("R9 no low_on latched", low_on, 0);
    oc_flag = 0; uv_flag = 0; ov_flag = 0;
    shdn_req = 1; cyc();
    chk("R6 shutdown", state_o, 5);
    shdn_req = 0; cyc();
    chk("R6 release starts soft", state_o, 1);
  endtask

  task automatic t_collide();
    to_run();
    oc_flag = 1; uv_flag = 1; cyc(); oc_flag = 0; uv_flag = 0;
    chk("R10 oc beats uv", state_o, 1);
    to_run();
    oc_flag = 1; shdn_req = 1; cyc(); oc_flag = 0;
    chk("R6 shutdown beats oc", state_o, 5);
    shdn_req = 0; cyc();
    // count was cleared: OCL-1 events must not latch
    for (int e = 1; e < OCL; e++) begin
      to_run(); oc_flag = 1; cyc(); oc_flag = 0;
    end
    chk("R6 count cleared", state_o, 1);
    to_run(); oc_flag = 1; cyc(); oc_flag = 0;
    chk("R5 latch after full count", state_o, 4);
    supply_ok = 0; cyc();
    chk("R2 supply loss clears latch", state_o, 0);
  endtask

  initial begin
    #4000000;
    bad++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_ramp();
    t_uv_mask();
    t_hiccup();
    t_ov();
    t_oc_latch();
    t_collide();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule